// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block produces the device-wide reset and keeps a record of what caused the most recent one. Its inputs are already digital. A power-on detect pulse resets everything at once, without waiting for a clock. An undervoltage comparator output starts a brown-out reset if it stays high long enough. The master-clear pin is active low. A watchdog time-out either resets the device or, when the core is asleep, only wakes it. Two configuration inputs enable brown-out detection and the power-up timer.

After power-on, reset is held while a power-up timer runs and then while an oscillator start-up count runs. Every other reset cause skips the power-up timer and goes straight to the start-up count. The power-up timer and the brown-out filter count pulses of a slow timebase tick. The start-up count uses oscillator clocks. All three lengths are parameters.

Four status flags, named POR, BOR, TO and PD, record the cause of the last reset. Hardware events change them, and software can overwrite them. All control and status pins are plain level or pulse signals with no handshake.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_det` is high, `sys_rst_n` is low immediately. After `por_det` falls, the internal reset takes two clock edges to release, and only then does the power-up sequence start.
- R2: Power-on leaves `flags` = {POR,BOR,TO,PD} = 4'b0111. Bit 3 is POR, bit 2 is BOR, bit 1 is TO and bit 0 is PD.
- R3: After power-on, the power-up phase behaves as follows:
  - With `cfg_pwrt_dis`=0, it lasts `PWRT_TICKS` tick pulses.
  - With `cfg_pwrt_dis`=1, it lasts one clock.
  - An oscillator start-up phase of `OST_CYCLES` clocks then follows before `sys_rst_n` rises.
  - With `cfg_pwrt_dis`=1, `sys_rst_n` rises at the 19th rising edge after `por_det` falls when `OST_CYCLES`=16.
- R4: The synchronized `uv_low` may stay high for `BOR_TICKS` ticks while `cfg_bor_en`=1. If it does:
  - A brown-out starts. It clears BOR and sets TO and PD. POR is left unchanged.
  - Reset is held for as long as `uv_low` stays high.
  - The start-up count runs after `uv_low` falls.
- R5: An undervoltage dip that spans fewer than `BOR_TICKS` ticks causes no reset and changes no flag.
- R6: With `cfg_bor_en`=0, `uv_low` has no effect on reset or flags.
- R7: While the synchronized `mclr_n` is low, reset is held. The start-up count runs after it returns high.
  - On the falling edge, if `in_sleep` is high, TO is set and PD is cleared.
  - Otherwise TO and PD keep their values. POR and BOR are never touched.
- R8: A `wdt_to` pulse while reset is released acts according to `in_sleep`:
  - With `in_sleep`=0, it resets through the start-up count and sets TO=0, PD=1.
  - With `in_sleep`=1, it only wakes: there is no reset, and TO=0, PD=0.
  - A `wdt_to` pulse while reset is held is ignored.
- R9: A non-power-on cause that arrives during the start-up phase restarts that count from zero. During the power-up phase, it does not shorten that phase.
- R10: When `sw_we` is high, `flags` loads `sw_wdata` (same bit order) at the next edge. A hardware event in the same cycle wins for the flags it touches. Among hardware events, brown-out wins, then master-clear, then watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_det | input | 1 | Power-on detect, active high, asynchronous assert |
| tick | input | 1 | One-cycle slow timebase pulse |
| uv_low | input | 1 | Undervoltage comparator output, high when supply is low |
| mclr_n | input | 1 | External master-clear, active low, asynchronous |
| wdt_to | input | 1 | One-cycle watchdog time-out pulse |
| in_sleep | input | 1 | Core is in sleep mode |
| cfg_bor_en | input | 1 | Brown-out detection enable |
| cfg_pwrt_dis | input | 1 | Power-up timer disable (0 enables the timer) |
| sw_we | input | 1 | Software write strobe for the flags |
| sw_wdata | input | 4 | Flag value written by software, {POR,BOR,TO,PD} |
| sys_rst_n | output | 1 | Device reset, active low |
| flags | output | 4 | Cause flags {POR,BOR,TO,PD} |

## Verification
The assertions assume the following about the inputs:
- `tick` and `wdt_to` are single-cycle pulses synchronous to `clk`.
- `in_sleep` is held steady around a master-clear edge.
- `sw_wdata` is valid whenever `sw_we` is high.

The stimulus drives every input just after a rising edge. It raises `tick` on every fourth cycle, pulses `wdt_to` for one cycle, and keeps `in_sleep` high for several cycles around each sleep event. A behavioural model in the bench follows reset and flags on every clock. Scenario checks then confirm the flag patterns and the release timing.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    PH_PWRT = 2'd0,
    PH_OST  = 2'd1,
    PH_RUN  = 2'd2
  } rsq_phase_e;

  localparam int F_POR = 3;
  localparam int F_BOR = 2;
  localparam int F_TO  = 1;
  localparam int F_PD  = 0;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= {WIDTH{RST_VAL}};
      q     <= {WIDTH{RST_VAL}};
    end else begin
      stage <= d;
      q     <= stage;
    end
  end
endmodule

// File: rtl/rsq_bor_filter.sv
module rsq_bor_filter #(
  parameter int BOR_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bor_en,
  input  logic uv_sync,
  output logic bor_hold
);
  localparam int CW = $clog2(BOR_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BOR_TICKS);

  logic [CW-1:0] cnt;
  logic          low_seen;

  assign low_seen = bor_en && uv_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!low_seen) begin
      cnt <= '0;
    end else if (tick && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign bor_hold = low_seen && (cnt == LIMIT);

  // R5: a hold needs the comparator to have been low on the previous cycle
  a_r5_needs_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_hold && !$past(bor_hold)) |-> $past(low_seen));
endmodule

// File: rtl/rsq_seq.sv
module rsq_seq
  import rsq_pkg::*;
#(
  parameter int PWRT_TICKS = 2880,
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       pwrt_dis,
  input  logic       restart,
  output rsq_phase_e phase
);
  localparam int TW = $clog2(PWRT_TICKS + 1);
  localparam int OW = $clog2(OST_CYCLES + 1);
  localparam logic [TW-1:0] T_LAST = TW'(PWRT_TICKS - 1);
  localparam logic [OW-1:0] O_LAST = OW'(OST_CYCLES - 1);

  logic [TW-1:0] tcnt;
  logic [OW-1:0] ocnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PWRT;
      tcnt  <= '0;
      ocnt  <= '0;
    end else begin
      unique case (phase)
        PH_PWRT: begin
          if (pwrt_dis) begin
            phase <= PH_OST;
            ocnt  <= '0;
          end else if (tick) begin
            if (tcnt == T_LAST) begin
              phase <= PH_OST;
              ocnt  <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        PH_OST: begin
          if (restart) begin
            ocnt <= '0;
          end else if (ocnt == O_LAST) begin
            phase <= PH_RUN;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        default: begin
          if (restart) begin
            phase <= PH_OST;
            ocnt  <= '0;
          end
        end
      endcase
    end
  end

  // R9: a cause outside the power-up phase re-enters the start-up count at zero
  a_r9_restart_ost: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && phase != PH_PWRT) |=> (phase == PH_OST && ocnt == '0));

  // R3: release only follows a complete start-up count
  a_r3_release_after_ost: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && $past(phase) != PH_RUN) |-> ($past(ocnt) == O_LAST));
endmodule

// File: rtl/rsq_flags.sv
module rsq_flags
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_we,
  input  logic [3:0] sw_wdata,
  input  logic       ev_bor,
  input  logic       ev_mclr,
  input  logic       ev_wdt,
  input  logic       in_sleep,
  output logic [3:0] flags
);
  logic [3:0] nxt;
  logic       any_ev;

  assign any_ev = ev_bor || ev_mclr || ev_wdt;

  always_comb begin
    nxt = flags;
    if (sw_we) nxt = sw_wdata;
    if (ev_wdt) begin
      nxt[F_TO] = 1'b0;
      nxt[F_PD] = !in_sleep;
    end
    if (ev_mclr && in_sleep) begin
      nxt[F_TO] = 1'b1;
      nxt[F_PD] = 1'b0;
    end
    if (ev_bor) begin
      nxt[F_BOR] = 1'b0;
      nxt[F_TO]  = 1'b1;
      nxt[F_PD]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 4'b0111;
    else        flags <= nxt;
  end

  // R10: with no event the software value lands unchanged
  a_r10_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !any_ev) |=> (flags == $past(sw_wdata)));

  // R2: power-on pattern while the internal reset is held
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      a_r2_por_flags: assert (flags == 4'b0111);
    end
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rsq_pkg::*;
#(
  parameter int PWRT_TICKS = 2880,
  parameter int BOR_TICKS  = 4,
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       por_det,
  input  logic       tick,
  input  logic       uv_low,
  input  logic       mclr_n,
  input  logic       wdt_to,
  input  logic       in_sleep,
  input  logic       cfg_bor_en,
  input  logic       cfg_pwrt_dis,
  input  logic       sw_we,
  input  logic [3:0] sw_wdata,
  output logic       sys_rst_n,
  output logic [3:0] flags
);
  logic       por_s1, rst_n;
  logic       mclr_s, mclr_prev, uv_s;
  logic       bor_hold, ev_mclr, ev_wdt, restart;
  rsq_phase_e phase;

  always_ff @(posedge clk or posedge por_det) begin
    if (por_det) begin
      por_s1 <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      por_s1 <= 1'b1;
      rst_n  <= por_s1;
    end
  end

  rsq_sync #(.WIDTH(1), .RST_VAL(1'b1)) i_mclr_sync (
    .clk(clk), .rst_n(rst_n), .d(mclr_n), .q(mclr_s));

  rsq_sync #(.WIDTH(1), .RST_VAL(1'b0)) i_uv_sync (
    .clk(clk), .rst_n(rst_n), .d(uv_low), .q(uv_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclr_prev <= 1'b1;
    else        mclr_prev <= mclr_s;
  end

  rsq_bor_filter #(.BOR_TICKS(BOR_TICKS)) i_bor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bor_en(cfg_bor_en),
    .uv_sync(uv_s), .bor_hold(bor_hold));

  assign ev_mclr = mclr_prev && !mclr_s;
  assign ev_wdt  = wdt_to && (phase == PH_RUN);
  assign restart = bor_hold || !mclr_s || (ev_wdt && !in_sleep);

  rsq_seq #(.PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES)) i_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwrt_dis(cfg_pwrt_dis),
    .restart(restart), .phase(phase));

  rsq_flags i_flags (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .ev_bor(bor_hold), .ev_mclr(ev_mclr), .ev_wdt(ev_wdt),
    .in_sleep(in_sleep), .flags(flags));

  assign sys_rst_n = (phase == PH_RUN);

  // R1: power-on detect always holds the device in reset
  a_r1_por_holds: assert property (@(posedge clk) por_det |-> !sys_rst_n);

  // R4: brown-out clears BOR and holds reset
  a_r4_bor_effect: assert property (@(posedge clk) disable iff (!rst_n)
    bor_hold |=> (!flags[F_BOR] && !sys_rst_n));

  // R6: disabled detection never produces a hold
  a_r6_bor_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bor_en |-> !bor_hold);

  // R7: master-clear low keeps reset asserted
  a_r7_mclr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_s |=> !sys_rst_n);

  // R8: a wake during sleep does not reset
  a_r8_wake_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_to && in_sleep && sys_rst_n && mclr_s && !bor_hold) |=> sys_rst_n);
endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
  localparam int PW = 4;
  localparam int BW = 3;
  localparam int OC = 16;

  logic clk = 1'b0;
  logic por_det = 1'b1, tick = 1'b0, uv_low = 1'b0, mclr_n = 1'b1, wdt_to = 1'b0;
  logic in_sleep = 1'b0, cfg_bor_en = 1'b1, cfg_pwrt_dis = 1'b0, sw_we = 1'b0;
  logic [3:0] sw_wdata = 4'h0;
  logic       sys_rst_n;
  logic [3:0] flags;

  always #2 clk = ~clk;

  reset_sequencer #(.PWRT_TICKS(PW), .BOR_TICKS(BW), .OST_CYCLES(OC)) i_reset_sequencer (
    .clk(clk), .por_det(por_det), .tick(tick), .uv_low(uv_low), .mclr_n(mclr_n),
    .wdt_to(wdt_to), .in_sleep(in_sleep), .cfg_bor_en(cfg_bor_en),
    .cfg_pwrt_dis(cfg_pwrt_dis), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sys_rst_n(sys_rst_n), .flags(flags));

  int    n_chk = 0, n_bad = 0, cyc = 0;
  bit    started = 0;
  string cur_req = "R1";

  // tick every fourth cycle, driven just after the edge
  always @(posedge clk) begin
    cyc++;
    #1 tick = (cyc % 4 == 3);
  end

  // behavioural reference model
  bit m_s1 = 0, m_s2 = 0, m_m1 = 1, m_m2 = 1, m_mp = 1, m_u1 = 0, m_u2 = 0;
  int m_bc = 0, m_tc = 0, m_oc = 0, m_ph = 0;
  logic [3:0] m_fl = 4'b0111;

  task automatic model_clear();
    m_m1 = 1; m_m2 = 1; m_mp = 1; m_u1 = 0; m_u2 = 0;
    m_bc = 0; m_tc = 0; m_oc = 0; m_ph = 0; m_fl = 4'b0111;
  endtask

  task automatic model_step();
    bit hold, mev, wgo, rs;
    logic [3:0] f;
    hold = cfg_bor_en && m_u2 && (m_bc == BW);
    mev  = m_mp && !m_m2;
    wgo  = wdt_to && (m_ph == 2);
    rs   = hold || !m_m2 || (wgo && !in_sleep);
    f = m_fl;
    if (sw_we) f = sw_wdata;
    if (wgo) begin f[1] = 0; f[0] = !in_sleep; end
    if (mev && in_sleep) begin f[1] = 1; f[0] = 0; end
    if (hold) begin f[2] = 0; f[1] = 1; f[0] = 1; end
    m_fl = f;
    if (m_ph == 0) begin
      if (cfg_pwrt_dis) begin m_ph = 1; m_oc = 0; end
      else if (tick) begin
        if (m_tc == PW - 1) begin m_ph = 1; m_oc = 0; end
        else m_tc++;
      end
    end else if (rs) begin
      m_ph = 1; m_oc = 0;
    end else if (m_ph == 1) begin
      if (m_oc == OC - 1) m_ph = 2;
      else m_oc++;
    end
    if (cfg_bor_en && m_u2) begin
      if (tick && m_bc < BW) m_bc++;
    end else m_bc = 0;
    m_mp = m_m2; m_m2 = m_m1; m_m1 = mclr_n;
    m_u2 = m_u1; m_u1 = uv_low;
  endtask

  always @(posedge clk or posedge por_det) begin
    if (por_det) begin
      m_s1 = 0; m_s2 = 0; model_clear();
    end else begin
      bit old2;
      old2 = m_s2; m_s2 = m_s1; m_s1 = 1;
      if (!old2) model_clear();
      else model_step();
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      n_chk++;
      if (sys_rst_n !== (m_ph == 2) || flags !== m_fl) begin
        n_bad++;
        $display("FAIL %s model compare: actual rst=%b flags=%b expected rst=%b flags=%b",
                 cur_req, sys_rst_n, flags, (m_ph == 2), m_fl);
      end
    end
  end

  task automatic tk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_release(input string req);
    int k;
    for (k = 0; k < 400 && sys_rst_n !== 1'b1; k++) tk(1);
    chk(req, {3'b0, sys_rst_n}, 4'b0001);
  endtask

  task automatic sw_write(input logic [3:0] v);
    sw_we = 1; sw_wdata = v; tk(1); sw_we = 0; tk(1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    tk(3);
    started = 1;
    // R1 R2: reset state
    chk("R1", {3'b0, sys_rst_n}, 4'b0000);
    chk("R2", flags, 4'b0111);
    cur_req = "R3";
    por_det = 0;
    tk(12);
    chk("R3", {3'b0, sys_rst_n}, 4'b0000);
    wait_release("R3");
    chk("R2", flags, 4'b0111);

    cur_req = "R10";
    sw_write(4'b1111);
    chk("R10", flags, 4'b1111);

    cur_req = "R5";
    uv_low = 1; tk(6); uv_low = 0; tk(10);
    chk("R5", {3'b0, sys_rst_n}, 4'b0001);
    chk("R5", flags, 4'b1111);

    cur_req = "R6";
    cfg_bor_en = 0; uv_low = 1; tk(40);
    chk("R6", {3'b0, sys_rst_n}, 4'b0001);
    chk("R6", flags, 4'b1111);
    uv_low = 0; tk(4); cfg_bor_en = 1; tk(2);

    cur_req = "R4";
    uv_low = 1; tk(30);
    chk("R4", {3'b0, sys_rst_n}, 4'b0000);
    chk("R4", flags, 4'b1011);
    uv_low = 0;
    wait_release("R4");

    cur_req = "R7";
    sw_write(4'b1100);
    mclr_n = 0; tk(5);
    chk("R7", {3'b0, sys_rst_n}, 4'b0000);
    chk("R7", flags, 4'b1100);
    mclr_n = 1;
    wait_release("R7");
    in_sleep = 1; tk(1); mclr_n = 0; tk(5); in_sleep = 0;
    chk("R7", flags, 4'b1110);
    mclr_n = 1;
    wait_release("R7");

    cur_req = "R8";
    sw_write(4'b1111);
    wdt_to = 1; tk(1); wdt_to = 0; tk(2);
    chk("R8", {3'b0, sys_rst_n}, 4'b0000);
    chk("R8", flags, 4'b1101);
    wait_release("R8");
    sw_write(4'b1111);
    in_sleep = 1; wdt_to = 1; tk(1); wdt_to = 0; tk(2); in_sleep = 0;
    chk("R8", {3'b0, sys_rst_n}, 4'b0001);
    chk("R8", flags, 4'b1100);
    sw_write(4'b1111);
    mclr_n = 0; tk(5);
    wdt_to = 1; tk(1); wdt_to = 0; tk(2);
    chk("R8", flags, 4'b1111);
    mclr_n = 1;
    wait_release("R8");

    cur_req = "R9";
    mclr_n = 0; tk(3); mclr_n = 1; tk(8);
    mclr_n = 0; tk(3); mclr_n = 1; tk(11);
    chk("R9", {3'b0, sys_rst_n}, 4'b0000);
    wait_release("R9");
    por_det = 1; tk(2); por_det = 0; tk(6);
    mclr_n = 0; tk(3); mclr_n = 1; tk(11);
    chk("R9", {3'b0, sys_rst_n}, 4'b0000);
    wait_release("R9");

    cur_req = "R3";
    cfg_pwrt_dis = 1;
    por_det = 1; tk(2); por_det = 0;
    tk(18);
    chk("R3", {3'b0, sys_rst_n}, 4'b0000);
    tk(1);
    chk("R3", {3'b0, sys_rst_n}, 4'b0001);
    chk("R2", flags, 4'b0111);

    tk(5);
    finish_run();
  end
endmodule